// File: doc/BRIEF.md
# Dual-Lane NOR Flash Command Engine

This block models the command decoder that sits inside a parallel NOR flash array built from two 16-bit devices wired side by side into a 32-bit word. The host issues bus writes and reads to word offsets. A write is treated as a command only when both 16-bit lanes carry the same byte. The engine selects what a read returns: array contents, identifier codes or the status register. It also sequences block erase, single-word program and lock clearing, each taking a fixed number of clock cycles set by parameters so that simulations stay short.

The array is a small register-based memory. The word index is the low address bits, and a block is a group of consecutive words. All blocks come out of reset locked. Software must clear the locks before any program or erase can take effect. A running erase can be suspended so that the array can be read, and later resumed. It then finishes with the cycles it had left.

Top module: `nor_cmd_engine`

## Requirements
- R1: A write is a command only if wdata[31:16] equals wdata[15:0] and wdata[15:8] is zero; the command byte is wdata[7:0]. Any other write made while idle changes nothing.
- R2: After reset the read mode is array, every word reads 0xFFFFFFFF, and all blocks are locked. Command 0xFF selects array read mode.
- R3: The write sequence 0xAA at offset 0x5555, 0x55 at 0x2AAA and 0x90 at 0x5555 enters identifier mode. In that mode offset 0 reads {2{16'h0089}} (manufacturer), offset 1 reads {2{16'h0018}} (device) and other offsets read 0. A sequence with any step wrong leaves the mode unchanged.
- R4: Command 0x70 selects status read mode. A status read returns {8'h00,S,8'h00,S}, where S bit 7 = ready, bit 6 = erase suspended, bit 5 = erase error, bit 4 = program error, and bits 3..0 are zero. Command 0x50 clears bits 5 and 4.
- R5: Command 0x60 followed by 0xD0 clears every block lock. A program to a locked block sets bit 4, an erase of a locked block sets bit 5, and in both cases the array is left unchanged.
- R6: Command 0x20 followed by 0xD0 erases the block that holds the address of the confirm write. The block is the index bits [IDX_W-1:IDX_W-BLK_W]. After exactly ERASE_CYCLES busy cycles every word of that block reads 0xFFFFFFFF, and other blocks keep their contents.
- R7: Command 0x40 followed by a data write programs that word. After PROG_CYCLES busy cycles it reads old AND data.
- R8: While an erase or program is busy, every read returns status with ready clear, and every write other than suspend (0xB0 during erase) is ignored. This includes a read-mode change. Afterwards the device is in status read mode.
- R9: Command 0xB0 during an erase suspends it: status reads 0xC0 and the array can be read unchanged. Command 0xD0 resumes the erase, which then completes.
- R10: An erase or lock-clear setup that is followed by any write other than 0xD0 sets both status bits 5 and 4 and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Word offset for reads and writes |
| wdata | input | 32 | Write data or duplicated command byte |
| rdata | output | 32 | Read data for addr in the current mode |

## Verification
The command stream is run through each read mode in turn, and reads after every step show which mode is active. Programming a word twice with overlapping bit patterns checks that programming is an AND and not an overwrite. Reads taken one cycle before and one cycle after the expected end of each operation pin down the exact busy length. An erase that is suspended, read through and then resumed shows that the suspended erase left the array untouched, and that the erase hit only its own block. Malformed commands, a wrong unlock step, a wrong confirm byte and writes to locked blocks are each followed by a read that shows nothing changed except the error bits.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE_SETUP,
        ST_PROG_SETUP,
        ST_LOCK_SETUP,
        ST_BUSY_ERASE,
        ST_BUSY_PROG,
        ST_SUSPENDED
    } eng_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_STATUS
    } read_mode_e;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_OTHER,
        CMD_READ_ARRAY,
        CMD_READ_STATUS,
        CMD_CLEAR_STATUS,
        CMD_ERASE,
        CMD_PROGRAM,
        CMD_LOCK_CLEAR,
        CMD_CONFIRM,
        CMD_SUSPEND,
        CMD_SEQ1,
        CMD_SEQ2,
        CMD_SEQ3
    } cmd_e;

    typedef struct packed {
        logic ready;
        logic suspended;
        logic erase_err;
        logic prog_err;
        logic [3:0] zero;
    } status_t;

    localparam logic [15:0] SEQ_ADDR_A = 16'h5555;
    localparam logic [15:0] SEQ_ADDR_B = 16'h2AAA;

    function automatic logic [31:0] lanes8(input logic [7:0] b);
        return {8'h00, b, 8'h00, b};
    endfunction

    function automatic logic [31:0] lanes16(input logic [15:0] h);
        return {h, h};
    endfunction

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
    import nor_cmd_pkg::*;
(
    input  logic [31:0] wdata,
    output cmd_e        cmd
);
    logic lanes_ok;
    assign lanes_ok = (wdata[31:16] == wdata[15:0]) && (wdata[15:8] == 8'h00);

    always_comb begin
        cmd = CMD_NONE;
        if (lanes_ok) begin
            case (wdata[7:0])
                8'hFF:   cmd = CMD_READ_ARRAY;
                8'h70:   cmd = CMD_READ_STATUS;
                8'h50:   cmd = CMD_CLEAR_STATUS;
                8'h20:   cmd = CMD_ERASE;
                8'h40:   cmd = CMD_PROGRAM;
                8'h60:   cmd = CMD_LOCK_CLEAR;
                8'hD0:   cmd = CMD_CONFIRM;
                8'hB0:   cmd = CMD_SUSPEND;
                8'hAA:   cmd = CMD_SEQ1;
                8'h55:   cmd = CMD_SEQ2;
                8'h90:   cmd = CMD_SEQ3;
                default: cmd = CMD_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assign done = (cnt == ONE) && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= load;
        end else if ((cnt != '0) && !hold) begin
            cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/nor_array.sv
module nor_array #(
    parameter int IDX_W = 6,
    parameter int BLK_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             erase_en,
    input  logic [BLK_W-1:0] erase_blk,
    input  logic             prog_en,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [31:0]      prog_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);
    localparam int WORDS = 1 << IDX_W;
    localparam int OFF_W = IDX_W - BLK_W;

    logic [31:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [BLK_W-1:0] BID = BLK_W'(g >> OFF_W);
        localparam logic [IDX_W-1:0] WID = IDX_W'(g);
        logic [31:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '1;
            end else if (erase_en && (erase_blk == BID)) begin
                word_q <= '1;
            end else if (prog_en && (prog_idx == WID)) begin
                word_q <= word_q & prog_data;
            end
        end

        assign words[g] = word_q;
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          IDX_W        = 6,
    parameter int          BLK_W        = 2,
    parameter int          ERASE_CYCLES = 12,
    parameter int          PROG_CYCLES  = 5,
    parameter logic [15:0] MFR_CODE     = 16'h0089,
    parameter logic [15:0] DEV_CODE     = 16'h0018
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int NBLK  = 1 << BLK_W;
    localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(SEQ_ADDR_A);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(SEQ_ADDR_B);

    eng_state_e       state_q;
    read_mode_e       mode_q;
    logic [1:0]       seq_q;
    logic [NBLK-1:0]  lock_q;
    logic             err_erase_q, err_prog_q;
    logic [BLK_W-1:0] tgt_blk_q;
    logic [IDX_W-1:0] tgt_idx_q;
    logic [31:0]      tgt_data_q;

    cmd_e             cmd;
    logic [IDX_W-1:0] idx;
    logic [BLK_W-1:0] blk;
    logic             tmr_start, tmr_hold, tmr_done;
    logic [CNT_W-1:0] tmr_load, tmr_cnt;
    logic             busy;
    status_t          status;
    logic [31:0]      arr_rd;

    assign idx  = addr[IDX_W-1:0];
    assign blk  = addr[IDX_W-1:IDX_W-BLK_W];
    assign busy = (state_q == ST_BUSY_ERASE) || (state_q == ST_BUSY_PROG);

    nor_cmd_decode u_dec (.wdata(wdata), .cmd(cmd));

    always_comb begin
        tmr_start = 1'b0;
        tmr_load  = CNT_W'(ERASE_CYCLES);
        if (wr_en && (state_q == ST_ERASE_SETUP) && (cmd == CMD_CONFIRM) && !lock_q[blk]) begin
            tmr_start = 1'b1;
        end else if (wr_en && (state_q == ST_PROG_SETUP) && !lock_q[blk]) begin
            tmr_start = 1'b1;
            tmr_load  = CNT_W'(PROG_CYCLES);
        end
    end
    assign tmr_hold = (state_q == ST_SUSPENDED);

    nor_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .start(tmr_start), .load(tmr_load),
        .hold(tmr_hold), .cnt(tmr_cnt), .done(tmr_done)
    );

    nor_array #(.IDX_W(IDX_W), .BLK_W(BLK_W)) u_arr (
        .clk(clk), .rst(rst),
        .erase_en(tmr_done && (state_q == ST_BUSY_ERASE)), .erase_blk(tgt_blk_q),
        .prog_en(tmr_done && (state_q == ST_BUSY_PROG)), .prog_idx(tgt_idx_q),
        .prog_data(tgt_data_q), .rd_idx(idx), .rd_data(arr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            mode_q      <= RM_ARRAY;
            seq_q       <= 2'd0;
            lock_q      <= '1;
            err_erase_q <= 1'b0;
            err_prog_q  <= 1'b0;
            tgt_blk_q   <= '0;
            tgt_idx_q   <= '0;
            tgt_data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (wr_en) begin
                    if (cmd == CMD_SEQ1 && addr == ADDR_A) begin
                        seq_q <= 2'd1;
                    end else if (seq_q == 2'd1 && cmd == CMD_SEQ2 && addr == ADDR_B) begin
                        seq_q <= 2'd2;
                    end else if (seq_q == 2'd2 && cmd == CMD_SEQ3 && addr == ADDR_A) begin
                        seq_q  <= 2'd0;
                        mode_q <= RM_IDENT;
                    end else begin
                        seq_q <= 2'd0;
                        case (cmd)
                            CMD_READ_ARRAY:   mode_q <= RM_ARRAY;
                            CMD_READ_STATUS:  mode_q <= RM_STATUS;
                            CMD_CLEAR_STATUS: begin
                                err_erase_q <= 1'b0;
                                err_prog_q  <= 1'b0;
                            end
                            CMD_ERASE:      begin state_q <= ST_ERASE_SETUP; mode_q <= RM_STATUS; end
                            CMD_PROGRAM:    begin state_q <= ST_PROG_SETUP;  mode_q <= RM_STATUS; end
                            CMD_LOCK_CLEAR: begin state_q <= ST_LOCK_SETUP;  mode_q <= RM_STATUS; end
                            default: ;
                        endcase
                    end
                end
                ST_ERASE_SETUP: if (wr_en) begin
                    if (cmd != CMD_CONFIRM) begin
                        err_erase_q <= 1'b1;
                        err_prog_q  <= 1'b1;
                        state_q     <= ST_IDLE;
                    end else if (lock_q[blk]) begin
                        err_erase_q <= 1'b1;
                        state_q     <= ST_IDLE;
                    end else begin
                        tgt_blk_q <= blk;
                        state_q   <= ST_BUSY_ERASE;
                    end
                end
                ST_PROG_SETUP: if (wr_en) begin
                    if (lock_q[blk]) begin
                        err_prog_q <= 1'b1;
                        state_q    <= ST_IDLE;
                    end else begin
                        tgt_idx_q  <= idx;
                        tgt_data_q <= wdata;
                        state_q    <= ST_BUSY_PROG;
                    end
                end
                ST_LOCK_SETUP: if (wr_en) begin
                    if (cmd == CMD_CONFIRM) begin
                        lock_q <= '0;
                    end else begin
                        err_erase_q <= 1'b1;
                        err_prog_q  <= 1'b1;
                    end
                    state_q <= ST_IDLE;
                end
                ST_BUSY_ERASE: begin
                    if (tmr_done) begin
                        state_q <= ST_IDLE;
                    end else if (wr_en && cmd == CMD_SUSPEND) begin
                        state_q <= ST_SUSPENDED;
                    end
                end
                ST_BUSY_PROG: if (tmr_done) state_q <= ST_IDLE;
                ST_SUSPENDED: if (wr_en) begin
                    case (cmd)
                        CMD_CONFIRM:      begin state_q <= ST_BUSY_ERASE; mode_q <= RM_STATUS; end
                        CMD_READ_ARRAY:   mode_q <= RM_ARRAY;
                        CMD_READ_STATUS:  mode_q <= RM_STATUS;
                        CMD_CLEAR_STATUS: begin
                            err_erase_q <= 1'b0;
                            err_prog_q  <= 1'b0;
                        end
                        default: ;
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        status.ready     = !busy;
        status.suspended = (state_q == ST_SUSPENDED);
        status.erase_err = err_erase_q;
        status.prog_err  = err_prog_q;
        status.zero      = 4'h0;
    end

    always_comb begin
        if (busy) begin
            rdata = lanes8(status);
        end else begin
            case (mode_q)
                RM_ARRAY: rdata = arr_rd;
                RM_IDENT: begin
                    if (addr == ADDR_W'(0))      rdata = lanes16(MFR_CODE);
                    else if (addr == ADDR_W'(1)) rdata = lanes16(DEV_CODE);
                    else                         rdata = 32'h0;
                end
                default:  rdata = lanes8(status);
            endcase
        end
    end
endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk
    import nor_cmd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input eng_state_e       state,
    input read_mode_e       mode,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic busy_st, well_formed;
    assign busy_st     = (state == ST_BUSY_ERASE) || (state == ST_BUSY_PROG);
    assign well_formed = (wdata[31:16] == wdata[15:0]) && (wdata[15:8] == 8'h00);

    assert_busy_reads_status_R8: assert property (@(posedge clk) disable iff (rst)
        busy_st |-> (rdata[23] == 1'b0 && rdata[7] == 1'b0 && rdata[31:16] == rdata[15:0]));

    assert_malformed_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && wr_en && !well_formed) |=> (state == ST_IDLE && $stable(mode)));

    assert_timer_steps_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_st && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

    assert_suspend_freezes_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUSPENDED) |=> (cnt == $past(cnt)));

    assert_bad_confirm_R10: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ERASE_SETUP || state == ST_LOCK_SETUP) && wr_en && wdata != 32'h00D000D0)
        |=> (state == ST_IDLE));
endmodule

bind nor_cmd_engine nor_cmd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .state(state_q), .mode(mode_q), .cnt(tmr_cnt)
);

// File: tb/test_nor_cmd_engine.sv
module test_nor_cmd_engine;
    localparam int AW = 16;
    localparam int EC = 12;
    localparam int PC = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    nor_cmd_engine #(.ADDR_W(AW), .IDX_W(6), .BLK_W(2), .ERASE_CYCLES(EC),
                     .PROG_CYCLES(PC)) i_nor_cmd_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    initial begin : monitor
        forever begin
            @(negedge clk);
            #4;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            finish_run();
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state
        rd(16'd3, 32'hFFFFFFFF, "R2 erased after reset");
        wr(0, 32'h00700070);
        rd(0, 32'h00800080, "R4 status ready");

        // R5 program to locked block fails
        wr(5, 32'h00400040);
        wr(5, 32'h12345678);
        rd(5, 32'h00900090, "R5 locked program error");
        wr(0, 32'h00500050);
        rd(0, 32'h00800080, "R4 clear status");
        wr(0, 32'h00FF00FF);
        rd(5, 32'hFFFFFFFF, "R5 locked word untouched");

        // R5 clear locks
        wr(0, 32'h00600060);
        wr(0, 32'h00D000D0);
        rd(0, 32'h00800080, "R5 lock clear ok");

        // R7 program with exact busy length
        wr(5, 32'h00400040);
        wr(5, 32'h12345678);
        rd(5, 32'h00000000, "R8 busy status");
        repeat (PC - 2) @(posedge clk);
        rd(5, 32'h00000000, "R7 last busy cycle");
        rd(5, 32'h00800080, "R7 ready after program");
        wr(0, 32'h00FF00FF);
        rd(5, 32'h12345678, "R7 programmed word");
        wr(5, 32'h00400040);
        wr(5, 32'h0F0F0F0F);
        repeat (PC + 1) @(posedge clk);
        wr(0, 32'h00FF00FF);
        rd(5, 32'h02040608, "R7 program is AND");
        wr(6, 32'h00400040);
        wr(6, 32'hAAAA5555);
        repeat (PC + 1) @(posedge clk);
        wr(20, 32'h00400040);
        wr(20, 32'h11112222);
        repeat (PC + 1) @(posedge clk);

        // R3 identifier mode
        wr(16'h5555, 32'h00AA00AA);
        wr(16'h2AAA, 32'h00550055);
        wr(16'h5555, 32'h00900090);
        rd(0, 32'h00890089, "R3 manufacturer");
        rd(1, 32'h00180018, "R3 device");
        rd(7, 32'h00000000, "R3 other offset");
        wr(0, 32'h00FF00FF);
        wr(16'h5555, 32'h00AA00AA);
        wr(16'h1234, 32'h00550055);
        wr(16'h5555, 32'h00900090);
        rd(5, 32'h02040608, "R3 broken sequence ignored");
        rd(6, 32'hAAAA5555, "R2 array read mode");

        // R1 malformed commands ignored
        wr(0, 32'h007000FF);
        rd(5, 32'h02040608, "R1 mismatched lanes");
        wr(0, 32'h01700170);
        rd(5, 32'h02040608, "R1 nonzero upper byte");

        // R9 erase block 0 with suspend and resume
        wr(3, 32'h00200020);
        wr(3, 32'h00D000D0);
        repeat (2) @(posedge clk);
        wr(0, 32'h00FF00FF);
        rd(5, 32'h00000000, "R8 write ignored while busy");
        wr(0, 32'h00B000B0);
        rd(0, 32'h00C000C0, "R9 suspended status");
        wr(0, 32'h00FF00FF);
        rd(5, 32'h02040608, "R9 array intact while suspended");
        wr(0, 32'h00700070);
        rd(0, 32'h00C000C0, "R9 status during suspend");
        wr(0, 32'h00D000D0);
        rd(0, 32'h00000000, "R9 resumed busy");
        repeat (EC) @(posedge clk);
        rd(0, 32'h00800080, "R9 erase completes");
        wr(0, 32'h00FF00FF);
        rd(5, 32'hFFFFFFFF, "R6 block word erased");
        rd(6, 32'hFFFFFFFF, "R6 second word erased");
        rd(20, 32'h11112222, "R6 other block kept");

        // R6 exact erase length on block 1
        wr(20, 32'h00200020);
        wr(20, 32'h00D000D0);
        repeat (EC - 1) @(posedge clk);
        rd(0, 32'h00000000, "R6 last busy cycle");
        rd(0, 32'h00800080, "R6 ready after erase");
        wr(0, 32'h00FF00FF);
        rd(20, 32'hFFFFFFFF, "R6 block 1 erased");

        // R10 bad confirm
        wr(0, 32'h00200020);
        wr(0, 32'h00FF00FF);
        rd(0, 32'h00B000B0, "R10 erase bad confirm");
        wr(0, 32'h00500050);
        wr(0, 32'h00600060);
        wr(0, 32'h00400040);
        rd(0, 32'h00B000B0, "R10 lock bad confirm");
        wr(0, 32'h00500050);
        rd(0, 32'h00800080, "R4 errors cleared");

        @(negedge clk);
        #6;
        done = 1'b1;
        finish_run();
    end
endmodule